// File: doc/BRIEF.md
# Parallel Panel Command/Data Port

This block lets software run single transfers on an 8080-style parallel panel bus. Each transfer is one command (index) write, one data write, or one data read. Software places a word in the outgoing-word register, waits for the busy flag in the status register to read 0, and then writes a start bit to a trigger register. The engine then drives the panel's chip-select, register-select, write and read strobes and the 16-bit data bus through a fixed sequence. Busy stays set for the whole sequence.

Two control bits live in the upper part of the outgoing word. Bit 28 marks the word as a write. Bit 24 chooses data (1) or command/index (0). The payload sits in bits 15:0. A field in the trigger word picks which panel gets the cycle; bit 1 picks the second panel in the default two-panel build. A read uses the same scheme through the incoming-word register. Its bit 24 sets register-select for the read. Once the read finishes, that register holds the sampled bus value in its low 16 bits.

Top module: `lcd_cmd_port`

## Requirements
- R1: After reset, every chip-select, the write strobe and the read strobe are high (inactive), the bus is not driven, the busy flag (status bit 1, address 2) reads 0, and the read-length register (address 5) reads RDLEN_RESET (3).
- R2: Writing address 3 with bit 0 set while idle starts a write cycle, provided outgoing-word bit 28 is 1. Busy reads 1 from the next cycle for exactly WR_PULSE+2 cycles.
- R3: A write cycle has three parts, all with one chip-select low and the bus driven with outgoing-word bits 15:0. First comes one setup cycle with the write strobe high. Then the write strobe is low for WR_PULSE cycles. Last comes one hold cycle with the write strobe high. The bus value stays fixed for the whole cycle.
- R4: During a write, register-select equals bit 24 of the outgoing word (1 = data, 0 = index).
- R5: Bit 1 of the trigger word picks the panel: 0 drives chip-select 0 low, 1 drives chip-select 1 low. At most one chip-select is ever low.
- R6: A write trigger is ignored when outgoing-word bit 28 is 0. No strobe or chip-select moves, and busy stays 0.
- R7: Writing address 4 with bit 0 set while idle starts a read. It has one setup cycle, then the read strobe is low for max(2, read-length) cycles. The bus is never driven during a read, and register-select equals incoming-word (address 1) bit 24.
- R8: The bus is sampled at the clock edge that ends the last read-strobe cycle. From then on, address 1 reads the sample in bits 15:0 with bits 31:16 zero, and busy is 0.
- R9: Read-length values 0 and 1 still give a two-cycle read strobe.
- R10: A trigger of either kind written while busy is ignored. A new outgoing word written during a cycle does not change the bus value of that cycle.
- R11: The write and read strobes are never low together, and neither is low unless a chip-select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write enable |
| host_addr | input | 3 | Register address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational on address) |
| pnl_cs_n | output | NUM_PANELS | Active-low chip-select, one per panel |
| pnl_rs | output | 1 | Register-select (1 = data, 0 = index) |
| pnl_wr_n | output | 1 | Active-low write strobe |
| pnl_rd_n | output | 1 | Active-low read strobe |
| pnl_db_out | output | 16 | Bus value driven toward the panel |
| pnl_db_oe | output | 1 | Bus drive enable |
| pnl_db_in | input | 16 | Bus value returned by the panel |

## Verification
Embedded properties watch on every cycle that at most one chip-select is low and that the two strobes never overlap. They also check that strobes appear only inside a selected cycle, that the bus is driven before the write strobe falls and stays stable while driven, that the bus is never driven during a read, that no read strobe is shorter than two cycles, and that a busy-time trigger never opens a new cycle. Other behaviour can only be shown by the bench's scenarios: which panel and which register-select value a given trigger produces, the exact length of a programmed read strobe, the value captured into the read register, and the rejection of unmarked write words.

// File: rtl/lcdport_pkg.sv
package lcdport_pkg;

    localparam int REG_W    = 32;
    localparam int BUS_W    = 16;
    localparam int PIDX_W   = 4;
    localparam int MARK_POS = 28;
    localparam int DSEL_POS = 24;
    localparam int BUSY_POS = 1;
    localparam int GO_POS   = 0;
    localparam int MIN_RD   = 2;

    typedef enum logic [2:0] {
        ADDR_WDATA  = 3'd0,
        ADDR_RDATA  = 3'd1,
        ADDR_STATUS = 3'd2,
        ADDR_WTRIG  = 3'd3,
        ADDR_RTRIG  = 3'd4,
        ADDR_RDLEN  = 3'd5
    } reg_addr_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WSTROBE,
        PH_WHOLD,
        PH_RSETUP,
        PH_RSTROBE
    } phase_e;

    typedef struct packed {
        logic              dsel;
        logic [PIDX_W-1:0] panel;
        logic [BUS_W-1:0]  payload;
    } xfer_t;

    function automatic int unsigned rd_span(input int unsigned prog);
        return (prog < MIN_RD) ? MIN_RD : prog;
    endfunction

endpackage

// File: rtl/lcdport_regs.sv
module lcdport_regs
    import lcdport_pkg::*;
#(
    parameter int RDLEN_W     = 4,
    parameter int RDLEN_RESET = 3,
    parameter int PSEL_W      = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [2:0]         host_addr,
    input  logic [REG_W-1:0]   host_wdata,
    output logic [REG_W-1:0]   host_rdata,
    input  logic               busy,
    input  logic               cap_valid,
    input  logic [BUS_W-1:0]   cap_data,
    output logic [REG_W-1:0]   wdata_q,
    output logic [REG_W-1:0]   rdata_q,
    output logic [RDLEN_W-1:0] rdlen_q,
    output logic               wtrig_go,
    output logic               rtrig_go,
    output logic [PSEL_W-1:0]  trig_sel
);

    always_comb begin
        wtrig_go = host_we && (host_addr == ADDR_WTRIG) && host_wdata[GO_POS];
        rtrig_go = host_we && (host_addr == ADDR_RTRIG) && host_wdata[GO_POS];
        trig_sel = host_wdata[PSEL_W:1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rdata_q <= '0;
            rdlen_q <= RDLEN_W'(RDLEN_RESET);
        end else begin
            if (host_we && host_addr == ADDR_WDATA) wdata_q <= host_wdata;
            if (host_we && host_addr == ADDR_RDLEN) rdlen_q <= host_wdata[RDLEN_W-1:0];
            if (cap_valid)
                rdata_q <= {{(REG_W-BUS_W){1'b0}}, cap_data};
            else if (host_we && host_addr == ADDR_RDATA)
                rdata_q <= host_wdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADDR_WDATA:  host_rdata = wdata_q;
            ADDR_RDATA:  host_rdata = rdata_q;
            ADDR_STATUS: host_rdata[BUSY_POS] = busy;
            ADDR_RDLEN:  host_rdata = REG_W'(rdlen_q);
            default:     host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lcdport_seq.sv
module lcdport_seq
    import lcdport_pkg::*;
#(
    parameter int WR_PULSE = 2,
    parameter int RDLEN_W  = 4,
    parameter int PSEL_W   = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wtrig_go,
    input  logic               rtrig_go,
    input  logic [PSEL_W-1:0]  trig_sel,
    input  logic               wr_mark,
    input  logic               wr_dsel,
    input  logic [BUS_W-1:0]   wr_payload,
    input  logic               rd_dsel,
    input  logic [RDLEN_W-1:0] rdlen_q,
    input  logic [BUS_W-1:0]   db_in,
    output logic               busy,
    output logic [PIDX_W-1:0]  panel,
    output logic               rs,
    output logic               wr_n,
    output logic               rd_n,
    output logic               oe,
    output logic [BUS_W-1:0]   db_out,
    output logic               cap_valid,
    output logic [BUS_W-1:0]   cap_data
);

    localparam int WR_CW = $clog2(WR_PULSE + 1);
    localparam int CNT_W = ((RDLEN_W > WR_CW) ? RDLEN_W : WR_CW) + 1;

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    xfer_t            xfer_q;

    always_comb begin
        busy      = (phase_q != PH_IDLE);
        panel     = xfer_q.panel;
        rs        = xfer_q.dsel;
        db_out    = xfer_q.payload;
        oe        = (phase_q == PH_WSETUP) || (phase_q == PH_WSTROBE) || (phase_q == PH_WHOLD);
        wr_n      = (phase_q != PH_WSTROBE);
        rd_n      = (phase_q != PH_RSTROBE);
        cap_valid = (phase_q == PH_RSTROBE) && (cnt_q == '0);
        cap_data  = db_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            xfer_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (wtrig_go && wr_mark) begin
                        xfer_q.dsel    <= wr_dsel;
                        xfer_q.panel   <= PIDX_W'(trig_sel);
                        xfer_q.payload <= wr_payload;
                        phase_q        <= PH_WSETUP;
                    end else if (rtrig_go) begin
                        xfer_q.dsel    <= rd_dsel;
                        xfer_q.panel   <= PIDX_W'(trig_sel);
                        cnt_q          <= CNT_W'(rd_span(int'(rdlen_q)) - 1);
                        phase_q        <= PH_RSETUP;
                    end
                end
                PH_WSETUP: begin
                    cnt_q   <= CNT_W'(WR_PULSE - 1);
                    phase_q <= PH_WSTROBE;
                end
                PH_WSTROBE: begin
                    if (cnt_q == '0) phase_q <= PH_WHOLD;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                PH_WHOLD:  phase_q <= PH_IDLE;
                PH_RSETUP: phase_q <= PH_RSTROBE;
                PH_RSTROBE: begin
                    if (cnt_q == '0) phase_q <= PH_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(!wr_n && !rd_n));

    assert_setup_before_wr_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> ($past(oe) && oe));

    assert_bus_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (oe && $past(oe)) |-> $stable(db_out));

    assert_read_no_drive_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !oe);

    assert_min_read_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> !$past(rd_n, 2));

    assert_busy_blocks_trigger_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && (wtrig_go || rtrig_go)) |=> (phase_q != PH_WSETUP && phase_q != PH_RSETUP));

endmodule

// File: rtl/lcdport_csdec.sv
module lcdport_csdec
    import lcdport_pkg::*;
#(
    parameter int NUM_PANELS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  active,
    input  logic [PIDX_W-1:0]     panel,
    output logic [NUM_PANELS-1:0] cs_n
);

    for (genvar i = 0; i < NUM_PANELS; i++) begin : g_cs
        assign cs_n[i] = !(active && (panel == PIDX_W'(i)));
    end

    assert_single_cs_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

endmodule

// File: rtl/lcd_cmd_port.sv
module lcd_cmd_port
    import lcdport_pkg::*;
#(
    parameter int NUM_PANELS  = 2,
    parameter int WR_PULSE    = 2,
    parameter int RDLEN_W     = 4,
    parameter int RDLEN_RESET = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [2:0]            host_addr,
    input  logic [31:0]           host_wdata,
    output logic [31:0]           host_rdata,
    output logic [NUM_PANELS-1:0] pnl_cs_n,
    output logic                  pnl_rs,
    output logic                  pnl_wr_n,
    output logic                  pnl_rd_n,
    output logic [15:0]           pnl_db_out,
    output logic                  pnl_db_oe,
    input  logic [15:0]           pnl_db_in
);

    localparam int PSEL_W = (NUM_PANELS > 1) ? $clog2(NUM_PANELS) : 1;

    logic               busy;
    logic               cap_valid;
    logic [BUS_W-1:0]   cap_data;
    logic [REG_W-1:0]   wdata_q;
    logic [REG_W-1:0]   rdata_q;
    logic [RDLEN_W-1:0] rdlen_q;
    logic               wtrig_go;
    logic               rtrig_go;
    logic [PSEL_W-1:0]  trig_sel;
    logic [PIDX_W-1:0]  panel;

    lcdport_regs #(
        .RDLEN_W(RDLEN_W), .RDLEN_RESET(RDLEN_RESET), .PSEL_W(PSEL_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .cap_valid(cap_valid), .cap_data(cap_data),
        .wdata_q(wdata_q), .rdata_q(rdata_q), .rdlen_q(rdlen_q),
        .wtrig_go(wtrig_go), .rtrig_go(rtrig_go), .trig_sel(trig_sel)
    );

    lcdport_seq #(
        .WR_PULSE(WR_PULSE), .RDLEN_W(RDLEN_W), .PSEL_W(PSEL_W)
    ) u_seq (
        .clk(clk), .rst(rst),
        .wtrig_go(wtrig_go), .rtrig_go(rtrig_go), .trig_sel(trig_sel),
        .wr_mark(wdata_q[MARK_POS]), .wr_dsel(wdata_q[DSEL_POS]),
        .wr_payload(wdata_q[BUS_W-1:0]), .rd_dsel(rdata_q[DSEL_POS]),
        .rdlen_q(rdlen_q), .db_in(pnl_db_in),
        .busy(busy), .panel(panel), .rs(pnl_rs),
        .wr_n(pnl_wr_n), .rd_n(pnl_rd_n), .oe(pnl_db_oe),
        .db_out(pnl_db_out), .cap_valid(cap_valid), .cap_data(cap_data)
    );

    lcdport_csdec #(.NUM_PANELS(NUM_PANELS)) u_cs (
        .clk(clk), .rst(rst),
        .active(busy), .panel(panel), .cs_n(pnl_cs_n)
    );

    assert_strobe_needs_cs_R11: assert property (@(posedge clk) disable iff (rst)
        (!pnl_wr_n || !pnl_rd_n) |-> (pnl_cs_n != {NUM_PANELS{1'b1}}));

endmodule

// File: tb/sim_lcd_cmd_port.sv
module sim_lcd_cmd_port;

    localparam int WR_PULSE = 2;
    localparam int RD_RESET = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic [1:0]  pnl_cs_n;
    logic        pnl_rs, pnl_wr_n, pnl_rd_n, pnl_db_oe;
    logic [15:0] pnl_db_out;
    logic [15:0] pnl_db_in = 16'h0000;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lcd_cmd_port #(.NUM_PANELS(2), .WR_PULSE(WR_PULSE), .RDLEN_W(4), .RDLEN_RESET(RD_RESET)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pnl_cs_n(pnl_cs_n), .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .pnl_db_out(pnl_db_out), .pnl_db_oe(pnl_db_oe), .pnl_db_in(pnl_db_in)
    );

    function automatic void chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    // Expected-pin entry: {kind[1:0], cap, cs_n[1:0], rs, wr_n, rd_n, oe, db[15:0]}
    // kind 0 idle, 1 write, 2 read
    function automatic logic [24:0] ent(input int kind, input bit cap, input logic [1:0] csn,
                                        input bit rs, input bit wrn, input bit rdn, input bit oe,
                                        input logic [15:0] db);
        return {2'(kind), cap, csn, rs, wrn, rdn, oe, db};
    endfunction

    logic [24:0] q[$];
    logic [24:0] cur;
    logic [31:0] m_wdata, m_rdata;
    int          m_rdlen;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur     = ent(0, 0, 2'b11, 0, 1, 1, 0, 16'h0);
            m_wdata = 0;
            m_rdata = 0;
            m_rdlen = RD_RESET;
        end else begin
            if (host_we && host_addr == 3'd0) m_wdata = host_wdata;
            if (host_we && host_addr == 3'd1) m_rdata = host_wdata;
            if (host_we && host_addr == 3'd5) m_rdlen = int'(host_wdata[3:0]);
            if (cur[22]) m_rdata = {16'h0, pnl_db_in};
            if (cur[24:23] == 2'd0 && host_we && host_wdata[0]) begin
                logic [1:0] csn;
                csn = host_wdata[1] ? 2'b01 : 2'b10;
                if (host_addr == 3'd3 && m_wdata[28]) begin
                    q.push_back(ent(1, 0, csn, m_wdata[24], 1, 1, 1, m_wdata[15:0]));
                    for (int i = 0; i < WR_PULSE; i++)
                        q.push_back(ent(1, 0, csn, m_wdata[24], 0, 1, 1, m_wdata[15:0]));
                    q.push_back(ent(1, 0, csn, m_wdata[24], 1, 1, 1, m_wdata[15:0]));
                end else if (host_addr == 3'd4) begin
                    int len;
                    len = (m_rdlen < 2) ? 2 : m_rdlen;
                    q.push_back(ent(2, 0, csn, m_rdata[24], 1, 1, 0, 16'h0));
                    for (int i = 0; i < len; i++)
                        q.push_back(ent(2, (i == len - 1), csn, m_rdata[24], 1, 0, 0, 16'h0));
                end
            end
            if (q.size() > 0) cur = q.pop_front();
            else              cur = ent(0, 0, 2'b11, 0, 1, 1, 0, 16'h0);
        end
    end

    // Per-clock comparison and strobe monitors, 5 ns after each rising edge
    int rd_run = 0, last_rd = 0, wr_falls = 0;
    logic prev_wr = 1'b1;
    logic [1:0] last_sel = 2'b00;

    always begin
        @(posedge clk);
        #5;
        if (!rst) begin
            logic [1:0] k;
            k = cur[24:23];
            if (k == 2'd0) begin
                chk({pnl_cs_n, pnl_wr_n, pnl_rd_n, pnl_db_oe} == 5'b11110, "R10 idle pins",
                    {27'd0, pnl_cs_n, pnl_wr_n, pnl_rd_n, pnl_db_oe}, 32'b11110);
            end else begin
                string tag;
                tag = (k == 2'd1) ? ((pnl_rs !== cur[19]) ? "R4 rs" : "R3 write pins") : "R7 read pins";
                chk({pnl_cs_n, pnl_rs, pnl_wr_n, pnl_rd_n, pnl_db_oe} == cur[21:16] &&
                    (!cur[16] || pnl_db_out == cur[15:0]), tag,
                    {10'd0, pnl_cs_n, pnl_rs, pnl_wr_n, pnl_rd_n, pnl_db_oe, pnl_db_out},
                    {10'd0, cur[21:0]});
            end
            if (!pnl_rd_n) rd_run++;
            else if (rd_run > 0) begin last_rd = rd_run; rd_run = 0; end
            if (prev_wr && !pnl_wr_n) wr_falls++;
            prev_wr = pnl_wr_n;
            if (pnl_cs_n != 2'b11) last_sel = ~pnl_cs_n;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        #1 host_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #2 d = host_rdata;
    endtask

    task automatic poll_busy(output int n);
        logic [31:0] s;
        n = 0;
        forever begin
            reg_read(3'd2, s);
            if (!s[1]) break;
            n++;
        end
    endtask

    task automatic do_read(input logic [31:0] word, input logic [15:0] pin, input bit sub,
                           input int exp_len, input string req_len);
        int n;
        logic [31:0] d;
        reg_write(3'd1, word);
        pnl_db_in = pin;
        reg_write(3'd4, sub ? 32'h3 : 32'h1);
        poll_busy(n);
        chk(n == exp_len + 1, "R7 read busy length", n, exp_len + 1);
        chk(last_rd == exp_len, req_len, last_rd, exp_len);
        pnl_db_in = ~pin;
        repeat (2) @(posedge clk);
        reg_read(3'd1, d);
        chk(d == {16'h0, pin}, "R8 captured read data", d, {16'h0, pin});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n, wf;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        reg_read(3'd2, d);
        chk(d[1] == 1'b0, "R1 busy after reset", d, 0);
        reg_read(3'd5, d);
        chk(d == RD_RESET, "R1 read length reset", d, RD_RESET);
        chk(pnl_cs_n == 2'b11 && pnl_wr_n && pnl_rd_n && !pnl_db_oe, "R1 idle pins",
            {pnl_cs_n, pnl_wr_n, pnl_rd_n, pnl_db_oe}, 5'b11110);

        // R2 R4 index write to main panel
        reg_write(3'd0, 32'h1000_002C);
        reg_write(3'd3, 32'h1);
        poll_busy(n);
        chk(n == WR_PULSE + 2, "R2 write busy length", n, WR_PULSE + 2);
        chk(last_sel == 2'b01, "R5 main panel selected", last_sel, 2'b01);

        // R5 data write to sub panel
        reg_write(3'd0, 32'h1100_ABCD);
        reg_write(3'd3, 32'h3);
        poll_busy(n);
        chk(n == WR_PULSE + 2, "R2 sub write busy length", n, WR_PULSE + 2);
        chk(last_sel == 2'b10, "R5 sub panel selected", last_sel, 2'b10);

        // R6 unmarked word ignored
        wf = wr_falls;
        reg_write(3'd0, 32'h0100_1234);
        reg_write(3'd3, 32'h1);
        reg_read(3'd2, d);
        chk(d[1] == 1'b0, "R6 unmarked write not busy", d, 0);
        repeat (5) @(posedge clk);
        chk(wr_falls == wf, "R6 no write strobe", wr_falls, wf);

        // R10 triggers and word changes during a busy write
        wf = wr_falls;
        reg_write(3'd0, 32'h1100_5555);
        reg_write(3'd3, 32'h1);
        reg_write(3'd0, 32'h1100_AAAA);
        reg_write(3'd3, 32'h3);
        poll_busy(n);
        repeat (3) @(posedge clk);
        chk(wr_falls == wf + 1, "R10 busy trigger ignored", wr_falls, wf + 1);
        chk(last_sel == 2'b01, "R10 panel of first trigger kept", last_sel, 2'b01);

        // R7 R8 read from main panel, default length
        do_read(32'h0100_0000, 16'hBEEF, 1'b0, 3, "R7 read strobe length");

        // R9 short programmed lengths
        reg_write(3'd5, 32'h0);
        do_read(32'h0100_0000, 16'h1357, 1'b1, 2, "R9 length 0 strobe");
        chk(last_sel == 2'b10, "R5 sub panel read", last_sel, 2'b10);
        reg_write(3'd5, 32'h1);
        do_read(32'h0000_0000, 16'h2468, 1'b0, 2, "R9 length 1 strobe");

        // R7 longer strobe, index read, with a write trigger during it (R10)
        reg_write(3'd5, 32'h6);
        wf = wr_falls;
        reg_write(3'd0, 32'h1100_0F0F);
        reg_write(3'd1, 32'h0000_0000);
        pnl_db_in = 16'h7E81;
        reg_write(3'd4, 32'h1);
        reg_write(3'd3, 32'h1);
        poll_busy(n);
        chk(last_rd == 6, "R7 length 6 strobe", last_rd, 6);
        chk(wr_falls == wf, "R10 write during read ignored", wr_falls, wf);
        reg_read(3'd1, d);
        chk(d == 32'h0000_7E81, "R8 read data after long strobe", d, 32'h0000_7E81);

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule